// File: doc/BRIEF.md
# Two-Wire Bus Occupancy Detector

This block watches the clock and data lines of a shared two-wire (I2C) bus and keeps one flag, `busy_o`. A controller on a multi-master bus reads the flag before it issues a START of its own. The block never drives the bus and does not decode bytes. It only tracks bus ownership: whether some other device could be in the middle of a transfer.

Both line inputs are raw pad samples and pass through a synchronizer inside the block. The flag is set when the lines show a START, meaning SDA falls while SCL is high. It is also set when SCL is seen low at any time, which covers a monitor that joined the bus after the START. The flag is cleared at once by a STOP, meaning SDA rises while SCL is high. It is also cleared once SCL has stayed high without a break for a configured idle time. That idle time is given in microseconds together with the clock frequency, and the block converts it to a cycle count (125 MHz and 50 us give 6250 cycles).

Top module: `i2c_busy_monitor`

## Requirements
- R1: After reset, with both lines held high and quiet, `busy_o` reads 0 and stays 0.
- R2: SCL held low sets `busy_o` no later than 3 clock cycles after the input goes low, even if no START was seen.
- R3: A START (SDA high-to-low while SCL stays high) sets `busy_o` within 3 clock cycles.
- R4: A STOP (SDA low-to-high while SCL stays high) clears `busy_o` within 3 clock cycles, without waiting for the idle time.
- R5: Once set, `busy_o` stays 1 while SCL is high for fewer than IDLE cycles, where IDLE = CLK_FREQ_HZ * IDLE_TIMEOUT_US / 1000000. It clears no later than IDLE+4 cycles after SCL was released high.
- R6: SDA changes while SCL is low have no effect: an SDA rise with SCL low does not clear `busy_o`.
- R7: Any low period of SCL restarts the idle count, so the idle time is measured from the last release of SCL.
- R8: A synchronous active-high `rst` clears `busy_o` and the idle count, even in the middle of a transfer.
- R9: A repeated START (SDA falls while SCL is high and the bus is already busy) keeps `busy_o` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Raw SCL line level, asynchronous |
| sda_in | input | 1 | Raw SDA line level, asynchronous |
| busy_o | output | 1 | Registered bus-occupied flag |

## Verification
The bench targets the two sides of the idle window. A design that clears one cycle too early would let the controller start a transfer on top of another device's slow clock. A design that never times out would hang the bus whenever a STOP is missed. A short SCL low pulse placed in the middle of the idle window catches a counter that is not restarted; such a design would free the bus early. An SDA rise while SCL is low catches a STOP detector that ignores the level of SCL; it would falsely declare the bus free in the middle of a byte. A repeated START and a reset during a transfer check that ownership is neither lost nor kept by mistake.

// File: rtl/i2c_busy_pkg.sv
package i2c_busy_pkg;

  // Idle window in clock cycles from clock frequency and timeout in microseconds
  function automatic int busy_idle_cycles(input longint clk_hz, input longint timeout_us);
    longint prod;
    prod = (clk_hz * timeout_us) / 64'sd1000000;
    if (prod < 2) prod = 2;
    return int'(prod);
  endfunction

  // Counter width able to hold values 0 .. n-1
  function automatic int busy_cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/busy_line_sync.sv
module busy_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] chain [STAGES];

  // Idle-high bus: every stage resets to all ones
  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '1;
    else     chain[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '1;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/busy_cond_detect.sv
module busy_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_low
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Conditions count only when SCL is high on both samples
  assign start_evt = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_evt  = scl_q & scl_s & ~sda_q & sda_s;
  assign scl_low   = ~scl_s;
endmodule

// File: rtl/busy_idle_timer.sv
module busy_idle_timer #(
  parameter int IDLE_CYCLES = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  import i2c_busy_pkg::*;
  localparam int CW = busy_cnt_width(IDLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_busy_monitor.sv
module i2c_busy_monitor #(
  parameter longint CLK_FREQ_HZ     = 125000000,
  parameter longint IDLE_TIMEOUT_US = 50,
  parameter int     SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy_o
);
  import i2c_busy_pkg::*;
  localparam int IDLE_CYCLES = busy_idle_cycles(CLK_FREQ_HZ, IDLE_TIMEOUT_US);

  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       start_evt, stop_evt, scl_low;
  logic       timeout_evt;
  logic       busy_q;

  busy_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({scl_in, sda_in}),
    .q_out (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  busy_cond_detect u_det (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_low   (scl_low)
  );

  busy_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (busy_q & scl_s),
    .expire (timeout_evt)
  );

  // Setting wins; clearing sources need SCL high so they never collide with scl_low
  always_ff @(posedge clk) begin
    if (rst)                           busy_q <= 1'b0;
    else if (start_evt || scl_low)     busy_q <= 1'b1;
    else if (stop_evt || timeout_evt)  busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/i2c_busy_monitor_chk.sv
module i2c_busy_monitor_chk #(
  parameter int IDLE_CYCLES = 6250
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic scl_s,
  input logic start_evt,
  input logic stop_evt,
  input logic scl_low,
  input logic timeout_evt
);
  localparam int CW = $clog2(IDLE_CYCLES + 2);
  logic [CW-1:0] hi_run;

  // Saturating run length of SCL-high samples
  always_ff @(posedge clk) begin
    if (rst || !scl_s)                     hi_run <= '0;
    else if (hi_run != CW'(IDLE_CYCLES))   hi_run <= hi_run + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_evt && !scl_low) |=> !busy);
  assert_scl_low_sets_R2: assert property (@(posedge clk) disable iff (rst)
    scl_low |=> busy);
  assert_start_sets_R3: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> busy);
  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !busy);
  assert_hold_until_event_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !stop_evt && !timeout_evt) |=> busy);
  assert_timeout_after_run_R7: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |-> (hi_run >= CW'(IDLE_CYCLES - 1)));
  assert_no_timeout_on_low_R6: assert property (@(posedge clk) disable iff (rst)
    scl_low |-> !timeout_evt && !stop_evt && !start_evt);
endmodule

bind i2c_busy_monitor i2c_busy_monitor_chk #(.IDLE_CYCLES(IDLE_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy_q),
  .scl_s       (scl_s),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .scl_low     (scl_low),
  .timeout_evt (timeout_evt)
);

// File: tb/i2c_busy_monitor_test.sv
`timescale 1ns/1ps
module i2c_busy_monitor_test;
  localparam longint CLK_HZ = 250000000;
  localparam longint TO_US  = 1;
  // Idle window restated: 250 cycles per microsecond times the timeout
  localparam int IDLE = int'((CLK_HZ / 1000000) * TO_US);
  localparam int NV = 17;

  // {scl, sda, expected busy, requirement number, hold cycles}
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 8'd1, 32'd10},        // R1 idle
    {1'b1, 1'b0, 1'b1, 8'd3, 32'd10},        // R3 START
    {1'b0, 1'b0, 1'b1, 8'd2, 32'd10},        // R2 SCL low
    {1'b0, 1'b1, 1'b1, 8'd6, 32'd10},        // R6 SDA rise with SCL low
    {1'b0, 1'b0, 1'b1, 8'd6, 32'd10},        // R6 SDA fall with SCL low
    {1'b1, 1'b0, 1'b1, 8'd5, 32'd10},        // R5 SCL released
    {1'b1, 1'b1, 1'b0, 8'd4, 32'd10},        // R4 STOP
    {1'b0, 1'b1, 1'b1, 8'd2, 32'd10},        // R2 low without START
    {1'b1, 1'b1, 1'b1, 8'd5, 32'd10},        // R5 held after release
    {1'b1, 1'b1, 1'b0, 8'd5, 32'(IDLE + 10)},// R5 idle timeout
    {1'b1, 1'b0, 1'b1, 8'd3, 32'd10},        // R3 START again
    {1'b0, 1'b0, 1'b1, 8'd2, 32'd10},
    {1'b0, 1'b1, 1'b1, 8'd6, 32'd10},
    {1'b1, 1'b1, 1'b1, 8'd9, 32'd10},
    {1'b1, 1'b0, 1'b1, 8'd9, 32'd10},        // R9 repeated START
    {1'b0, 1'b0, 1'b1, 8'd2, 32'd10},
    {1'b1, 1'b0, 1'b1, 8'd5, 32'd10}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic busy_o;
  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_busy_monitor #(.CLK_FREQ_HZ(CLK_HZ), .IDLE_TIMEOUT_US(TO_US), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .busy_o(busy_o)
  );

  task automatic check(input string req, input logic exp);
    applied++;
    if (busy_o !== exp) begin
      miscompares++;
      $display("FAIL %s: busy_o=%b expected %b at %0t", req, busy_o, exp, $time);
    end
  endtask

  task automatic drive(input logic s, input logic d);
    @(negedge clk);
    scl_in = s;
    sda_in = d;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      applied++;
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", 1'b0);               // R1 reset state

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][42], VEC[i][41]);
      cycles(int'(VEC[i][31:0]));
      check($sformatf("R%0d vector %0d", VEC[i][39:32], i), VEC[i][40]);
    end

    // Return to idle with a STOP
    drive(1'b1, 1'b1);
    cycles(6);
    check("R4", 1'b0);

    // R2: set within 3 cycles of SCL going low
    drive(1'b0, 1'b1);
    cycles(3);
    check("R2", 1'b1);

    // R5: not released before IDLE cycles, released by IDLE+4
    drive(1'b1, 1'b1);
    cycles(IDLE - 3);
    check("R5", 1'b1);
    cycles(7);
    check("R5", 1'b0);

    // R7: a short low pulse inside the window restarts the count
    drive(1'b0, 1'b1);
    cycles(5);
    drive(1'b1, 1'b1);
    cycles(IDLE - 20);
    drive(1'b0, 1'b1);
    cycles(3);
    drive(1'b1, 1'b1);
    cycles(IDLE - 20);
    check("R7", 1'b1);
    cycles(30);
    check("R7", 1'b0);

    // R4: STOP clears well before the window ends
    drive(1'b1, 1'b0);
    cycles(20);
    check("R3", 1'b1);
    drive(1'b1, 1'b1);
    cycles(3);
    check("R4", 1'b0);

    // R8: reset in the middle of a transfer
    drive(1'b0, 1'b0);
    cycles(6);
    check("R8", 1'b1);
    drive(1'b1, 1'b1);
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    check("R8", 1'b0);
    cycles(8);
    check("R8", 1'b0);

    done = 1'b1;
    summary();
  end
endmodule